// File: doc/BRIEF.md
# Precise Exception Recognizer with Drain-Gated Delivery

This block decides when an out-of-order core has to leave its normal instruction flow, and it delivers that decision only once the machine is quiet. Every cycle it looks at the instruction at the head of the retirement queue, at whether instruction fetch is stalled on a translation miss, at the external interrupt level, and at a request to change execution mode. At most one exception can be pending at a time. Once one is pending, every other source is ignored until that exception has been taken.

Recognising an exception and delivering it are two separate steps. Recognition sets a pending flag and stores a cause. Delivery fires a one-cycle take pulse, together with the stored cause, only when no operation is still executing and no work is queued. While an exception is pending but the pipeline is not yet drained, the block raises a waiting indicator and counts the cycles spent waiting.

The pipeline uses the block by sampling `take_exc` and `exc_cause`, and by feeding back its in-flight count and work flag. A performance monitor can read `wait_cnt`.

Top module: `exc_recognizer`

## Requirements
- R1: After reset, `take_exc`, `exc_wait`, `exc_cause` and `wait_cnt` are all zero.
- R2: Recognise a fetch-translation-miss exception (cause 0) when `head_vld` is 0 and `itlb_stall` is 1.
- R3: Recognise a fetch-translation-miss exception when `head_vld` is 1 only if `head_branch` is 1 and `head_spec` is 0. Otherwise `itlb_stall` has no effect.
- R4: Recognise an interrupt (cause 1) when `irq_pend` is 1 and the head is interruptible.
- R5: The head is not interruptible while `head_vld`, `head_uc_load` and `head_xfer_busy` are all 1. In that case `irq_pend` is ignored.
- R6: Recognise a mode-switch exception (cause 2) when `sw_req` is 1, `cur_pc` is below the parameter `REGION_TOP`, and `in_dslot` is 0.
- R7: When several sources qualify in the same cycle, the recorded cause is the translation miss first, then the interrupt, then the mode switch. Cause value 3 never appears.
- R8: A pending exception is taken only in a cycle where `exec_cnt` is 0 and `work_pend` is 0. The take decision made at clock edge N shows on the outputs right after that edge. `take_exc` is high for exactly one cycle, `exc_cause` carries the cause, and the pending flag clears. Sources are first sampled at the edge after recognition, so a take comes at least two edges after the source cycle.
- R9: While an exception is pending, no new source is recognised, and the cause that is delivered is the first one recorded.
- R10: At each edge where an exception is pending and the pipeline is not drained, `exc_wait` is 1 and `wait_cnt` increases by one, saturating at its maximum. A take clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_vld | input | 1 | Retirement queue holds at least one instruction |
| head_branch | input | 1 | Head instruction is a branch |
| head_spec | input | 1 | Head instruction is speculative (under an unresolved branch) |
| head_uc_load | input | 1 | Head is an uncached load holding a buffer entry |
| head_xfer_busy | input | 1 | Head's data transfer is still outstanding |
| itlb_stall | input | 1 | Fetch is stalled on an instruction-translation miss |
| irq_pend | input | 1 | External interrupt level |
| exec_cnt | input | CNT_W | Count of operations still executing |
| work_pend | input | 1 | Queued work not yet started |
| sw_req | input | 1 | Mode-switch request |
| cur_pc | input | PC_W | PC of the retiring stream |
| in_dslot | input | 1 | Current instruction sits in a branch delay position |
| take_exc | output | 1 | One-cycle exception delivery pulse |
| exc_cause | output | 2 | Cause of the last delivered exception |
| exc_wait | output | 1 | Pending exception is waiting for the pipeline to drain |
| wait_cnt | output | WAIT_W | Cycles spent waiting on the current exception |

## Verification
The bench aims at these corner cases:
- Simultaneous sources. A wrong priority order would deliver the interrupt or the mode-switch code where the translation-miss code belongs.
- A new source while an exception is pending. A design that lets a later source overwrite the stored cause would report the wrong reason.
- The two cases that block a source: the uncached load with its transfer in flight, and a PC at or above the region boundary, including exactly at the boundary. A design that misses either would take a spurious exception.
- A pipeline that drains partway. Here `exec_cnt` drops to zero while `work_pend` is still high. A design that tests only one of the two would take too early and leave the wait counter short.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [1:0] CAUSE_ITLB = 2'd0;
  localparam logic [1:0] CAUSE_IRQ  = 2'd1;
  localparam logic [1:0] CAUSE_MODE = 2'd2;
  localparam int         NUM_SRC    = 3;
endpackage

// File: rtl/exc_source_qual.sv
module exc_source_qual
  import exc_pkg::*;
#(
  parameter int          PC_W       = 32,
  parameter logic [31:0] REGION_TOP = 32'hC000_0000
) (
  input  logic            busy_i,
  input  logic            head_vld,
  input  logic            head_branch,
  input  logic            head_spec,
  input  logic            head_uc_load,
  input  logic            head_xfer_busy,
  input  logic            itlb_stall,
  input  logic            irq_pend,
  input  logic            sw_req,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            in_dslot,
  output logic            hit_o,
  output logic [1:0]      cause_o
);
  localparam logic [PC_W-1:0] TOP = PC_W'(REGION_TOP);

  logic [NUM_SRC-1:0] req;
  logic [1:0]         code [NUM_SRC];
  logic               head_blocks_irq;

  assign head_blocks_irq = head_vld & head_uc_load & head_xfer_busy;

  // index order is priority order: lowest index wins
  assign req[0]  = itlb_stall & (~head_vld | (head_branch & ~head_spec));
  assign req[1]  = irq_pend & ~head_blocks_irq;
  assign req[2]  = sw_req & (cur_pc < TOP) & ~in_dslot;
  assign code[0] = CAUSE_ITLB;
  assign code[1] = CAUSE_IRQ;
  assign code[2] = CAUSE_MODE;

  always_comb begin
    hit_o   = 1'b0;
    cause_o = CAUSE_ITLB;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i] && !busy_i) begin
        hit_o   = 1'b1;
        cause_o = code[i];
      end
    end
  end
endmodule

// File: rtl/exc_drain_ctrl.sv
module exc_drain_ctrl #(
  parameter int CNT_W  = 6,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_i,
  input  logic [1:0]        cause_i,
  input  logic [CNT_W-1:0]  exec_cnt,
  input  logic              work_pend,
  output logic              pend_o,
  output logic              take_o,
  output logic [1:0]        cause_o,
  output logic              wait_o,
  output logic [WAIT_W-1:0] wait_cnt_o
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = '1;

  logic       pend_q;
  logic [1:0] held_cause_q;
  logic       drained;
  logic       fire;
  logic       stall;

  assign drained = (exec_cnt == '0) && !work_pend;
  assign fire    = pend_q && drained;
  assign stall   = pend_q && !drained;
  assign pend_o  = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q       <= 1'b0;
      held_cause_q <= 2'd0;
      take_o       <= 1'b0;
      cause_o      <= 2'd0;
      wait_o       <= 1'b0;
      wait_cnt_o   <= '0;
    end else begin
      take_o <= fire;
      wait_o <= stall;
      if (fire) begin
        pend_q     <= 1'b0;
        cause_o    <= held_cause_q;
        wait_cnt_o <= '0;
      end else if (stall) begin
        if (wait_cnt_o != WAIT_MAX) wait_cnt_o <= wait_cnt_o + 1'b1;
      end else if (hit_i) begin
        pend_q       <= 1'b1;
        held_cause_q <= cause_i;
      end
    end
  end
endmodule

// File: rtl/exc_recognizer.sv
module exc_recognizer #(
  parameter int          CNT_W      = 6,
  parameter int          PC_W       = 32,
  parameter int          WAIT_W     = 16,
  parameter logic [31:0] REGION_TOP = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              head_vld,
  input  logic              head_branch,
  input  logic              head_spec,
  input  logic              head_uc_load,
  input  logic              head_xfer_busy,
  input  logic              itlb_stall,
  input  logic              irq_pend,
  input  logic [CNT_W-1:0]  exec_cnt,
  input  logic              work_pend,
  input  logic              sw_req,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              in_dslot,
  output logic              take_exc,
  output logic [1:0]        exc_cause,
  output logic              exc_wait,
  output logic [WAIT_W-1:0] wait_cnt
);
  logic       pend;
  logic       hit;
  logic [1:0] cause;

  exc_source_qual #(.PC_W(PC_W), .REGION_TOP(REGION_TOP)) u_qual (
    .busy_i(pend), .head_vld(head_vld), .head_branch(head_branch),
    .head_spec(head_spec), .head_uc_load(head_uc_load),
    .head_xfer_busy(head_xfer_busy), .itlb_stall(itlb_stall),
    .irq_pend(irq_pend), .sw_req(sw_req), .cur_pc(cur_pc),
    .in_dslot(in_dslot), .hit_o(hit), .cause_o(cause)
  );

  exc_drain_ctrl #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_drain (
    .clk(clk), .rst(rst), .hit_i(hit), .cause_i(cause),
    .exec_cnt(exec_cnt), .work_pend(work_pend), .pend_o(pend),
    .take_o(take_exc), .cause_o(exc_cause), .wait_o(exc_wait),
    .wait_cnt_o(wait_cnt)
  );
endmodule

// File: rtl/exc_recognizer_chk.sv
module exc_recognizer_chk #(
  parameter int CNT_W  = 6,
  parameter int WAIT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  exec_cnt,
  input logic              work_pend,
  input logic              take_exc,
  input logic [1:0]        exc_cause,
  input logic              exc_wait,
  input logic [WAIT_W-1:0] wait_cnt
);
  localparam logic [WAIT_W-1:0] WMAX = '1;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!take_exc && !exc_wait && wait_cnt == '0)); // R1

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    exc_cause != 2'd3); // R7

  AST_TAKE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> ($past(exec_cnt) == '0 && !$past(work_pend))); // R8

  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    take_exc |=> !take_exc); // R8

  AST_WAIT_EXCL: assert property (@(posedge clk) disable iff (rst)
    exc_wait |-> !take_exc); // R10

  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (rst)
    (exc_wait && $past(exc_wait) && $past(wait_cnt) != WMAX)
      |-> wait_cnt == $past(wait_cnt) + 1'b1); // R10

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    take_exc |-> (wait_cnt == '0 && !exc_wait)); // R10
endmodule

bind exc_recognizer exc_recognizer_chk #(.CNT_W(CNT_W), .WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst(rst), .exec_cnt(exec_cnt), .work_pend(work_pend),
  .take_exc(take_exc), .exc_cause(exc_cause), .exc_wait(exc_wait),
  .wait_cnt(wait_cnt)
);

// File: tb/test_exc_recognizer.sv
`timescale 1ns/1ps
module test_exc_recognizer;
  localparam int          CNT_W  = 6;
  localparam int          PC_W   = 32;
  localparam int          WAIT_W = 16;
  localparam logic [31:0] TOP    = 32'hC000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic head_vld = 0, head_branch = 0, head_spec = 0, head_uc_load = 0;
  logic head_xfer_busy = 0, itlb_stall = 0, irq_pend = 0, work_pend = 0;
  logic sw_req = 0, in_dslot = 0;
  logic [CNT_W-1:0]  exec_cnt = '0;
  logic [PC_W-1:0]   cur_pc = '0;
  logic              take_exc, exc_wait;
  logic [1:0]        exc_cause;
  logic [WAIT_W-1:0] wait_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state, built from the requirements
  bit              m_pend, m_take, m_wait;
  logic [1:0]      m_held, m_cause;
  logic [WAIT_W-1:0] m_cnt;

  always #4 clk = ~clk;

  exc_recognizer #(.CNT_W(CNT_W), .PC_W(PC_W), .WAIT_W(WAIT_W), .REGION_TOP(TOP)) i_exc_recognizer (
    .clk(clk), .rst(rst), .head_vld(head_vld), .head_branch(head_branch),
    .head_spec(head_spec), .head_uc_load(head_uc_load),
    .head_xfer_busy(head_xfer_busy), .itlb_stall(itlb_stall),
    .irq_pend(irq_pend), .exec_cnt(exec_cnt), .work_pend(work_pend),
    .sw_req(sw_req), .cur_pc(cur_pc), .in_dslot(in_dslot),
    .take_exc(take_exc), .exc_cause(exc_cause), .exc_wait(exc_wait),
    .wait_cnt(wait_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // recognised source this cycle: 0/1/2, or -1 for none (R2..R7)
  function automatic int src_pick();
    if (itlb_stall && (!head_vld || (head_branch && !head_spec))) return 0;
    if (irq_pend && !(head_vld && head_uc_load && head_xfer_busy)) return 1;
    if (sw_req && cur_pc < TOP && !in_dslot) return 2;
    return -1;
  endfunction

  task automatic model_edge();
    bit drained;
    int s;
    drained = (exec_cnt == 0) && !work_pend;
    s = src_pick();
    m_take = m_pend && drained;
    m_wait = m_pend && !drained;
    if (m_take) begin
      m_cause = m_held; m_cnt = '0; m_pend = 0;
    end else if (m_wait) begin
      if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
    end else if (s >= 0) begin
      m_pend = 1; m_held = 2'(s);
    end
  endtask

  task automatic step(input string tag);
    model_edge();
    @(posedge clk); #1;
    chk(take_exc == m_take, {tag, " R8 take"}, take_exc, m_take);
    chk(exc_cause == m_cause, {tag, " R7 cause"}, exc_cause, m_cause);
    chk(exc_wait == m_wait, {tag, " R10 wait"}, exc_wait, m_wait);
    chk(wait_cnt == m_cnt, {tag, " R10 count"}, wait_cnt, m_cnt);
  endtask

  task automatic quiet();
    head_vld = 0; head_branch = 0; head_spec = 0; head_uc_load = 0;
    head_xfer_busy = 0; itlb_stall = 0; irq_pend = 0; work_pend = 0;
    sw_req = 0; in_dslot = 0; exec_cnt = '0; cur_pc = 32'h1000;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_take = 0; m_wait = 0; m_held = 0; m_cause = 0; m_cnt = '0;
    quiet();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk(!take_exc && !exc_wait && exc_cause == 0 && wait_cnt == 0, "R1 reset", take_exc, 0);

    // R2: empty queue, fetch translation miss
    itlb_stall = 1; step("R2 latch"); quiet(); step("R2 take");
    chk(take_exc == 1 && exc_cause == 0, "R2 cause", exc_cause, 0);
    step("R2 idle");

    // R3: non-empty head, not a resolved branch: ignored
    head_vld = 1; head_branch = 1; head_spec = 1; itlb_stall = 1;
    step("R3 spec"); step("R3 spec2");
    chk(take_exc == 0 && exc_wait == 0, "R3 spec ignored", take_exc, 0);
    head_spec = 0; step("R3 latch"); quiet(); step("R3 take");
    chk(take_exc == 1 && exc_cause == 0, "R3 branch head", exc_cause, 0);

    // R5: blocked interrupt, then R4 once transfer finishes
    head_vld = 1; head_uc_load = 1; head_xfer_busy = 1; irq_pend = 1;
    step("R5 block"); step("R5 block2");
    chk(take_exc == 0, "R5 uc load blocks", take_exc, 0);
    head_xfer_busy = 0; step("R4 latch"); quiet(); step("R4 take");
    chk(take_exc == 1 && exc_cause == 1, "R4 irq cause", exc_cause, 1);

    // R6: boundary PC is not below the region top, delay slot blocks
    sw_req = 1; cur_pc = TOP; step("R6 edge"); step("R6 edge2");
    chk(take_exc == 0, "R6 pc at top ignored", take_exc, 0);
    cur_pc = TOP - 1; in_dslot = 1; step("R6 dslot"); step("R6 dslot2");
    chk(take_exc == 0, "R6 delay slot ignored", take_exc, 0);
    in_dslot = 0; step("R6 latch"); quiet(); step("R6 take");
    chk(take_exc == 1 && exc_cause == 2, "R6 mode cause", exc_cause, 2);

    // R7: all three at once, then irq+switch
    itlb_stall = 1; irq_pend = 1; sw_req = 1; cur_pc = 32'h10;
    step("R7 all"); quiet(); step("R7 all take");
    chk(exc_cause == 0, "R7 itlb first", exc_cause, 0);
    irq_pend = 1; sw_req = 1; cur_pc = 32'h10;
    step("R7 two"); quiet(); step("R7 two take");
    chk(exc_cause == 1, "R7 irq before switch", exc_cause, 1);

    // R9 + R10: pending while undrained, later source must not overwrite
    sw_req = 1; cur_pc = 32'h20; exec_cnt = 3;
    step("R9 latch"); sw_req = 0; irq_pend = 1; itlb_stall = 1;
    step("R10 w1"); step("R10 w2");
    chk(wait_cnt == 2 && exc_wait, "R10 count two", wait_cnt, 2);
    irq_pend = 0; itlb_stall = 0; exec_cnt = 0; work_pend = 1;
    step("R8 partial drain");
    chk(take_exc == 0, "R8 work still queued", take_exc, 0);
    work_pend = 0; step("R9 take");
    chk(take_exc == 1 && exc_cause == 2, "R9 first cause kept", exc_cause, 2);
    chk(wait_cnt == 0, "R10 cleared", wait_cnt, 0);
    step("R8 pulse end");
    chk(take_exc == 0, "R8 single pulse", take_exc, 0);

    // random phase, fixed seed
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      head_vld       = $urandom_range(0, 1);
      head_branch    = $urandom_range(0, 1);
      head_spec      = $urandom_range(0, 1);
      head_uc_load   = $urandom_range(0, 1);
      head_xfer_busy = $urandom_range(0, 1);
      itlb_stall     = ($urandom_range(0, 7) == 0);
      irq_pend       = ($urandom_range(0, 5) == 0);
      sw_req         = ($urandom_range(0, 5) == 0);
      in_dslot       = $urandom_range(0, 1);
      cur_pc         = ($urandom_range(0, 3) == 0) ? TOP + $urandom_range(0, 2) - 1 : $urandom;
      exec_cnt       = ($urandom_range(0, 2) == 0) ? CNT_W'($urandom_range(1, 9)) : '0;
      work_pend      = ($urandom_range(0, 3) == 0);
      step("rand R2-R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule